// File: doc/BRIEF.md
# Frequency-Locked Loop Digital Controller

This block closes a frequency-locked loop around a digitally controlled oscillator. A slow reference clock (nominally 32.768 kHz) is divided to form a fixed measurement window of `REF_DIV` reference cycles. Inside each window a counter running on the oscillator clock counts rising edges. At the end of the window the finished count moves into the reference domain through a toggle handshake. There it is compared with a programmed set count. The oscillator control code then moves one step toward the target, and it saturates at both ends of its range.

While the loop is disabled the code holds, and software can load a new code at any time. An optional spreading mode adds the state of an 8-bit maximal-length LFSR to the code that drives the oscillator. The LFSR advances once per window. A lock flag reports that the measured count has stayed within a small tolerance of the target for several consecutive windows.

Top module: `fll_ctrl`

## Requirements
- R1: While reset is asserted and right after its release, `loop_code` and `dco_code` equal 2^(CODE_W-1) and `locked` is 0.
- R2: The count used in each decision is the number of DCO rising edges in one window of `REF_DIV` reference cycles (100 edges for a 1.6 ns DCO period and 200 for 0.8 ns, with a 160 ns window).
- R3: With the loop enabled, every completed window moves `loop_code` by +1 when the count is below `set_count`, by -1 when it is above, and by 0 when they are equal. The code never changes by more than one step per reference cycle except on a load.
- R4: `loop_code` saturates: it stays at 0 when asked to step down, and at 2^CODE_W-1 when asked to step up.
- R5: While `loop_en` is 0 and no load occurs, `loop_code` holds its value and `locked` is 0 one reference cycle later.
- R6: A one-cycle `code_ld` pulse places `code_wdata` in `loop_code` on the next reference edge. The load takes priority over the loop and clears `locked`.
- R7: With `spread_en` at 0, `dco_code` equals `loop_code`.
- R8: With `spread_en` at 1, `dco_code` equals min(`loop_code` + dither, 2^CODE_W-1). The dither starts at 0x01 after reset and advances once per window. It shifts toward the MSB, and its new LSB is the XOR of bits 7, 5, 4 and 3, so it is never zero.
- R9: `locked` rises after `LOCK_WIN` consecutive windows whose count is within ±`LOCK_TOL` of `set_count`, and it falls after a window outside that band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that forms the window; all control logic runs on it |
| dco_clk | input | 1 | Clock from the controlled oscillator being measured |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| loop_en | input | 1 | Enables code updates from the measurement |
| spread_en | input | 1 | Adds the LFSR dither to the applied code |
| set_count | input | CNT_W (13) | Target DCO edge count per window |
| code_ld | input | 1 | Load strobe for the code register |
| code_wdata | input | CODE_W (18) | Value loaded on `code_ld` |
| loop_code | output | CODE_W (18) | Loop code register, without dither |
| dco_code | output | CODE_W (18) | Code applied to the oscillator |
| locked | output | 1 | Frequency lock indication |

## Verification
The bench keeps the default parameters: a 16-cycle window, a 13-bit count, an 18-bit code, and a lock after 4 windows within ±1. Because the reference runs at 100 MHz, a window lasts 160 ns. DCO periods of 0.8 ns and 1.6 ns then give exact, phase-stable counts of 200 and 100, so each step direction, the equal case and both saturation ends of the full 18-bit code can be checked against exact values. In closed-loop mode the oscillator model makes the count equal to the code. One code step is then one count, and lock is reached within a few tens of windows.

// File: rtl/fll_pkg.sv
package fll_pkg;

    localparam int DITHER_W = 8;
    // x^8 + x^6 + x^5 + x^4 + 1 : feedback from bits 7,5,4,3
    localparam logic [DITHER_W-1:0] DITHER_TAPS = 8'b1011_1000;
    localparam logic [DITHER_W-1:0] DITHER_SEED = 8'h01;

    typedef logic [DITHER_W-1:0] dither_t;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;

    function automatic dither_t dither_step(input dither_t s);
        return {s[DITHER_W-2:0], ^(s & DITHER_TAPS)};
    endfunction

endpackage

// File: rtl/fll_gate_div.sv
module fll_gate_div #(
    parameter int REF_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_tgl,
    output logic win_tick
);
    localparam int DW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          tgl;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == DW'(REF_DIV - 1));
        if (wrap) begin
            st_d.cnt = '0;
            st_d.tgl = ~st_q.tgl;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_tgl  = st_q.tgl;
    assign win_tick = wrap;
endmodule

// File: rtl/fll_dco_count.sv
module fll_dco_count #(
    parameter int CNT_W = 13
) (
    input  logic             dco_clk,
    input  logic             rst_n,
    input  logic             win_tgl,
    output logic [CNT_W-1:0] cnt_hold,
    output logic             ack_tgl
);
    typedef struct packed {
        logic [2:0]       sync;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
        logic             ack;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], win_tgl};
        if (st_q.sync[2] != st_q.sync[1]) begin
            // window boundary: freeze the finished count, this edge opens the next one
            st_d.hold = st_q.cnt;
            st_d.cnt  = CNT_W'(1);
            st_d.ack  = ~st_q.ack;
        end else if (st_q.cnt != '1) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge dco_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_hold = st_q.hold;
    assign ack_tgl  = st_q.ack;
endmodule

// File: rtl/fll_dither.sv
module fll_dither
    import fll_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    adv,
    output dither_t value
);
    dither_t lf_d, lf_q;

    always_comb begin
        lf_d = lf_q;
        if (adv) lf_d = dither_step(lf_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lf_q <= DITHER_SEED;
        else        lf_q <= lf_d;
    end

    assign value = lf_q;
endmodule

// File: rtl/fll_ctrl.sv
module fll_ctrl
    import fll_pkg::*;
#(
    parameter int REF_DIV  = 16,
    parameter int CNT_W    = 13,
    parameter int CODE_W   = 18,
    parameter int LOCK_WIN = 4,
    parameter int LOCK_TOL = 1
) (
    input  logic              ref_clk,
    input  logic              dco_clk,
    input  logic              rst_n,
    input  logic              loop_en,
    input  logic              spread_en,
    input  logic [CNT_W-1:0]  set_count,
    input  logic              code_ld,
    input  logic [CODE_W-1:0] code_wdata,
    output logic [CODE_W-1:0] loop_code,
    output logic [CODE_W-1:0] dco_code,
    output logic              locked
);
    localparam int                LW       = $clog2(LOCK_WIN + 1);
    localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(1) << (CODE_W - 1);

    typedef struct packed {
        logic [2:0]        ack_sync;
        logic [CODE_W-1:0] code;
        logic [LW-1:0]     lock_cnt;
        logic              locked;
    } loop_state_t;

    loop_state_t       st_d, st_q;
    logic              win_tgl, win_tick, ack_tgl, meas, in_tol;
    logic [CNT_W-1:0]  cnt_hold, err;
    dither_t           dither;
    step_dir_e         dir;
    logic [CODE_W:0]   dsum;

    fll_gate_div #(.REF_DIV(REF_DIV)) u_div (
        .clk(ref_clk), .rst_n(rst_n), .win_tgl(win_tgl), .win_tick(win_tick)
    );

    fll_dco_count #(.CNT_W(CNT_W)) u_cnt (
        .dco_clk(dco_clk), .rst_n(rst_n), .win_tgl(win_tgl),
        .cnt_hold(cnt_hold), .ack_tgl(ack_tgl)
    );

    fll_dither u_dith (
        .clk(ref_clk), .rst_n(rst_n), .adv(win_tick), .value(dither)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ack_sync = {st_q.ack_sync[1:0], ack_tgl};
        meas          = st_q.ack_sync[2] ^ st_q.ack_sync[1];

        if (cnt_hold < set_count)      dir = DIR_UP;
        else if (cnt_hold > set_count) dir = DIR_DOWN;
        else                           dir = DIR_HOLD;

        err    = (cnt_hold > set_count) ? (cnt_hold - set_count) : (set_count - cnt_hold);
        in_tol = (err <= CNT_W'(LOCK_TOL));

        if (code_ld) begin
            st_d.code     = code_wdata;
            st_d.lock_cnt = '0;
            st_d.locked   = 1'b0;
        end else if (!loop_en) begin
            st_d.lock_cnt = '0;
            st_d.locked   = 1'b0;
        end else if (meas) begin
            case (dir)
                DIR_UP:   if (st_q.code != '1) st_d.code = st_q.code + 1'b1;
                DIR_DOWN: if (st_q.code != '0) st_d.code = st_q.code - 1'b1;
                default:  st_d.code = st_q.code;
            endcase
            if (in_tol) begin
                if (st_q.lock_cnt != LW'(LOCK_WIN)) st_d.lock_cnt = st_q.lock_cnt + 1'b1;
            end else begin
                st_d.lock_cnt = '0;
            end
            st_d.locked = (st_d.lock_cnt == LW'(LOCK_WIN));
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ack_sync <= '0;
            st_q.code     <= CODE_RST;
            st_q.lock_cnt <= '0;
            st_q.locked   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        dsum = {1'b0, st_q.code} + (CODE_W + 1)'(dither);
        if (!spread_en)      dco_code = st_q.code;
        else if (dsum[CODE_W]) dco_code = '1;
        else                 dco_code = dsum[CODE_W-1:0];
    end

    assign loop_code = st_q.code;
    assign locked    = st_q.locked;
endmodule

// File: rtl/fll_ctrl_chk.sv
module fll_ctrl_chk #(
    parameter int CODE_W = 18
) (
    input logic              ref_clk,
    input logic              rst_n,
    input logic              loop_en,
    input logic              spread_en,
    input logic              code_ld,
    input logic [CODE_W-1:0] code_wdata,
    input logic [CODE_W-1:0] loop_code,
    input logic [CODE_W-1:0] dco_code,
    input logic              locked
);
    // R3
    single_step_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !code_ld |=> (loop_code == $past(loop_code) ||
                      loop_code == $past(loop_code) + 1 ||
                      loop_code == $past(loop_code) - 1));

    // R5
    hold_when_off_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!loop_en && !code_ld) |=> $stable(loop_code));

    // R5
    unlock_when_off_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !loop_en |=> !locked);

    // R6
    load_value_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        code_ld |=> (loop_code == $past(code_wdata) && !locked));

    // R7
    no_spread_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !spread_en |-> dco_code == loop_code);

    // R8
    spread_offset_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        spread_en |-> (dco_code > loop_code || dco_code == {CODE_W{1'b1}}));
endmodule

bind fll_ctrl fll_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .ref_clk(ref_clk), .rst_n(rst_n), .loop_en(loop_en), .spread_en(spread_en),
    .code_ld(code_ld), .code_wdata(code_wdata), .loop_code(loop_code),
    .dco_code(dco_code), .locked(locked)
);

// File: tb/fll_ctrl_tb.sv
`timescale 1ns/1ps
module fll_ctrl_tb;
    localparam int REF_DIV = 16;
    localparam int CNT_W   = 13;
    localparam int CODE_W  = 18;
    localparam int MAXC    = (1 << CODE_W) - 1;
    localparam int NWIN    = 6;

    // period_ps, set_count, loaded code, final code low, final code high
    localparam int TBL [7][5] = '{
        '{1600,  150,   1000,   1005,   1007},  // R3 up, R2 count 100
        '{1600,   50,   1000,    993,    995},  // R3 down
        '{1600,  100,   1000,   1000,   1000},  // R3 equal
        '{ 800,  150,      3,      0,      0},  // R4 floor, R2 count 200
        '{1600,  150, 262142, 262143, 262143},  // R4 ceiling
        '{ 800,  250,    500,    505,    507},  // R2 count 200 below set
        '{ 800, 4000,      7,     12,     14}   // R3 far target
    };

    logic              ref_clk = 0, dco_clk, rst_n = 0;
    logic              loop_en = 0, spread_en = 0, code_ld = 0;
    logic [CNT_W-1:0]  set_count = '0;
    logic [CODE_W-1:0] code_wdata = '0;
    logic [CODE_W-1:0] loop_code, dco_code;
    logic              locked;

    int  total = 0, bad = 0;
    int  period_ps = 1600;
    bit  closed = 0;

    fll_ctrl #(.REF_DIV(REF_DIV), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_dut (
        .ref_clk(ref_clk), .dco_clk(dco_clk), .rst_n(rst_n), .loop_en(loop_en),
        .spread_en(spread_en), .set_count(set_count), .code_ld(code_ld),
        .code_wdata(code_wdata), .loop_code(loop_code), .dco_code(dco_code),
        .locked(locked)
    );

    always #5 ref_clk = ~ref_clk;

    function automatic real half_ns();
        int c;
        if (closed) begin
            c = (int'(dco_code) < 10) ? 10 : int'(dco_code);
            return 80.0 / real'(c);
        end
        return real'(period_ps) / 2000.0;
    endfunction

    initial begin
        dco_clk = 0;
        #0.3;
        forever begin
            #(half_ns());
            dco_clk = ~dco_clk;
        end
    end

    function automatic logic [7:0] lfsr_next(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic load(input int v);
        code_wdata = CODE_W'(v);
        code_ld = 1;
        cyc(1);
        code_ld = 0;
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int prev;
        logic [7:0] dprev, dcur;
        bit got;

        cyc(3);
        // R1 during reset
        check(loop_code == 18'h20000, "R1 loop_code", loop_code, 18'h20000);
        check(dco_code == 18'h20000, "R1 dco_code", dco_code, 18'h20000);
        check(locked == 0, "R1 locked", locked, 0);
        rst_n = 1;
        cyc(1);
        check(loop_code == 18'h20000, "R1 after release", loop_code, 18'h20000);

        // R2 R3 R4 table walk
        foreach (TBL[i]) begin
            loop_en   = 0;
            period_ps = TBL[i][0];
            set_count = CNT_W'(TBL[i][1]);
            cyc(3 * REF_DIV);
            load(TBL[i][2]);
            check(loop_code == CODE_W'(TBL[i][2]), "R6 load", loop_code, TBL[i][2]);
            loop_en = 1;
            cyc(NWIN * REF_DIV);
            loop_en = 0;
            cyc(1);
            check(int'(loop_code) >= TBL[i][3] && int'(loop_code) <= TBL[i][4],
                  $sformatf("R3 row %0d", i), loop_code, TBL[i][3]);
            check(dco_code == loop_code, "R7 no spread", dco_code, loop_code);
        end

        // R5 loop off holds code
        period_ps = 800;
        set_count = 13'd100;
        load(5000);
        prev = int'(loop_code);
        cyc(10 * REF_DIV);
        check(int'(loop_code) == prev, "R5 hold", loop_code, prev);
        check(locked == 0, "R5 locked off", locked, 0);

        // R8 dither sequence
        spread_en = 1;
        cyc(1);
        dprev = 8'(dco_code - loop_code);
        check(dprev != 0, "R8 dither nonzero", dprev, 1);
        for (int k = 0; k < 10; k++) begin
            cyc(REF_DIV);
            dcur = 8'(dco_code - loop_code);
            check(dcur == lfsr_next(dprev), "R8 lfsr step", dcur, lfsr_next(dprev));
            dprev = dcur;
        end
        // R8 saturation
        load(MAXC - 1);
        cyc(1);
        check(int'(dco_code) == MAXC, "R8 clamp", dco_code, MAXC);
        spread_en = 0;
        cyc(1);
        check(int'(dco_code) == MAXC - 1, "R7 spread off", dco_code, MAXC - 1);

        // R9 closed loop lock
        set_count = 13'd100;
        load(90);
        closed  = 1;
        loop_en = 1;
        got = 0;
        for (int k = 0; k < 80 * REF_DIV && !got; k++) begin
            cyc(1);
            if (locked) got = 1;
        end
        check(got, "R9 lock reached", got, 1);
        check(int'(loop_code) >= 96 && int'(loop_code) <= 104, "R9 code near target",
              loop_code, 100);

        // R5 disable drops lock
        loop_en = 0;
        cyc(1);
        check(locked == 0, "R5 unlock on disable", locked, 0);

        // R9 lock falls after an out-of-band window
        loop_en = 1;
        got = 0;
        for (int k = 0; k < 80 * REF_DIV && !got; k++) begin
            cyc(1);
            if (locked) got = 1;
        end
        check(got, "R9 relock", got, 1);
        closed    = 0;
        period_ps = 800;
        cyc(4 * REF_DIV);
        check(locked == 0, "R9 lock lost", locked, 0);

        // R6 load overrides running loop
        load(1234);
        check(int'(loop_code) == 1234 && locked == 0, "R6 load priority", loop_code, 1234);
        loop_en = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule